// File: doc/BRIEF.md
# Four-Phase Bundled-Data Two-Way Multiplexer Controller

This block is the handshake controller that sits beside a two-input data multiplexer in a four-phase bundled-data pipeline. It has two data input channels (`in0`, `in1`), a select channel and one output channel. Each channel has a request and an acknowledge. The select channel also carries a select bit that is valid while its request is high. The controller chooses one of the two inputs and passes that input's request on to the output. It acknowledges the chosen input and the select channel once the output has acknowledged. It also drives the select of a data multiplexer whose width is set by a parameter.

A one-bit selection memory records which input was chosen. It is cleared when a select of 1 arrives and is set again once both the output acknowledge and the select request have returned to zero. The return-to-zero half of the handshake then releases the correct input, even when the other input is already requesting. Every state-holding gate is modelled as a clocked set/reset cell with a defined reset value. Each transition of an output therefore takes effect one clock after the input transition that causes it.

Top module: `hs_bd_mux_ctl`

## Requirements
- R1: The input that is not selected is never acknowledged, even while its request is high. `in0_ack` and `in1_ack` are never high together.
- R2: The selected input's acknowledge rises one clock after `out_ack` rises and falls one clock after `out_ack` falls. It never rises unless `out_req` was high.
- R3: `out_req` rises only while `ctl_req` is high and the selected input requests. `ctl_sel`=1 selects `in1` and `ctl_sel`=0 selects `in0`. A data request alone never raises `out_req`.
- R4: `out_req` stays high while `ctl_req` is high. It returns to 0 only once `ctl_req` and the selected input's request are both low.
- R5: `ctl_ack` rises one clock after `out_ack` rises. It falls only after `out_ack` is low and the selection memory has returned to its `in0` state.
- R6: `out_data` equals `in1_data` when `in1` is selected and `in0_data` otherwise. The choice stays fixed from the rise of `out_req` until the fall of `out_ack`, whatever the unselected input's data do.
- R7: While reset is asserted, and on leaving it, `out_req`, `ctl_ack`, `in0_ack` and `in1_ack` are 0. The selection memory points to `in0`, so `out_data` follows `in0_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the state-holding cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_req | input | 1 | Request of data input 0 |
| in0_ack | output | 1 | Acknowledge to data input 0 |
| in0_data | input | DATA_W | Data bundled with input 0 |
| in1_req | input | 1 | Request of data input 1 |
| in1_ack | output | 1 | Acknowledge to data input 1 |
| in1_data | input | DATA_W | Data bundled with input 1 |
| ctl_req | input | 1 | Request of the select channel |
| ctl_sel | input | 1 | Select bit bundled with `ctl_req` (1 picks input 1) |
| ctl_ack | output | 1 | Acknowledge to the select channel |
| out_req | output | 1 | Request of the output channel |
| out_ack | input | 1 | Acknowledge from the output channel |
| out_data | output | DATA_W | Multiplexed data bundled with `out_req` |

## Verification
A selection memory holding the wrong value shows at the ports within one clock of `out_ack` rising. The wrong input is acknowledged, or `in0_ack` and `in1_ack` disagree with the select that was sent. It also shows as soon as `out_req` rises, because `out_data` then follows the wrong input. If the memory fails to return to its `in0` state after an `in1` transfer, `ctl_ack` stays high after `out_ack` has fallen, and the next transfer stalls until the handshake wait times out. A wrong hold term on `out_req` shows as `out_req` dropping while `ctl_req` is still high, or never dropping after both requests have fallen.

// File: rtl/hs_bd_mux_pkg.sv
package hs_bd_mux_pkg;

    // Set and clear terms of the state-holding cells
    typedef struct packed {
        logic req_set;
        logic req_clr;
        logic cack_set;
        logic cack_clr;
        logic pick_set;
        logic pick_clr;
    } hs_terms_t;

    // Registered input acknowledges
    typedef struct packed {
        logic in0;
        logic in1;
    } hs_acks_t;

    localparam logic PICK_IN0 = 1'b1;

endpackage

// File: rtl/hs_gc_cell.sv
// Set/reset state-holding cell: set wins, otherwise clear, otherwise hold.
module hs_gc_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;
    logic q_q;

    always_comb begin
        q_d = q_q;
        if (set_i) begin
            q_d = 1'b1;
        end else if (clr_i) begin
            q_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= RST_VAL;
        end else begin
            q_q <= q_d;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/hs_data_sel.sv
// Bitwise two-way data multiplexer steered by the controller.
module hs_data_sel #(
    parameter int DATA_W = 8
) (
    input  logic              pick1_i,
    input  logic [DATA_W-1:0] d0_i,
    input  logic [DATA_W-1:0] d1_i,
    output logic [DATA_W-1:0] d_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign d_o[b] = pick1_i ? d1_i[b] : d0_i[b];
    end
endmodule

// File: rtl/hs_bd_mux_ctl.sv
module hs_bd_mux_ctl
    import hs_bd_mux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in0_req,
    output logic              in0_ack,
    input  logic [DATA_W-1:0] in0_data,
    input  logic              in1_req,
    output logic              in1_ack,
    input  logic [DATA_W-1:0] in1_data,
    input  logic              ctl_req,
    input  logic              ctl_sel,
    output logic              ctl_ack,
    output logic              out_req,
    input  logic              out_ack,
    output logic [DATA_W-1:0] out_data
);
    hs_terms_t terms;
    hs_acks_t  acks_d;
    hs_acks_t  acks_q;
    logic      pick0_q;   // 1: input 0 remembered, 0: input 1 remembered
    logic      req_q;
    logic      cack_q;

    always_comb begin
        terms.req_set  = ctl_req & ((in1_req & ~pick0_q) | (in0_req & ~ctl_sel));
        terms.req_clr  = ~ctl_req & ((~in1_req & ~pick0_q) | (~in0_req & pick0_q));
        terms.cack_set = out_ack;
        terms.cack_clr = ~out_ack & pick0_q;
        terms.pick_set = ~out_ack & ~ctl_req;
        terms.pick_clr = ctl_req & ctl_sel;
        acks_d.in0     = out_ack & pick0_q;
        acks_d.in1     = out_ack & ~pick0_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks_q <= '0;
        end else begin
            acks_q <= acks_d;
        end
    end

    hs_gc_cell #(.RST_VAL(1'b0)) u_req_cell (
        .clk(clk), .rst_n(rst_n),
        .set_i(terms.req_set), .clr_i(terms.req_clr), .q_o(req_q)
    );

    hs_gc_cell #(.RST_VAL(1'b0)) u_cack_cell (
        .clk(clk), .rst_n(rst_n),
        .set_i(terms.cack_set), .clr_i(terms.cack_clr), .q_o(cack_q)
    );

    hs_gc_cell #(.RST_VAL(PICK_IN0)) u_pick_cell (
        .clk(clk), .rst_n(rst_n),
        .set_i(terms.pick_set), .clr_i(terms.pick_clr), .q_o(pick0_q)
    );

    hs_data_sel #(.DATA_W(DATA_W)) u_data_sel (
        .pick1_i(~pick0_q),
        .d0_i(in0_data),
        .d1_i(in1_data),
        .d_o(out_data)
    );

    assign out_req = req_q;
    assign ctl_ack = cack_q;
    assign in0_ack = acks_q.in0;
    assign in1_ack = acks_q.in1;
endmodule

// File: rtl/hs_bd_mux_ctl_chk.sv
module hs_bd_mux_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_req,
    input logic out_req,
    input logic out_ack,
    input logic ctl_ack,
    input logic in0_ack,
    input logic in1_ack
);
    a_r1_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in0_ack && in1_ack));

    a_r2_ack_after_out_req: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in0_ack) || $rose(in1_ack)) |-> $past(out_req));

    a_r3_out_req_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> $past(ctl_req));

    a_r4_out_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && ctl_req) |=> out_req);

    a_r5_ctl_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_ack) |=> ctl_ack);
endmodule

bind hs_bd_mux_ctl hs_bd_mux_ctl_chk u_chk (.*);

// File: tb/test_hs_bd_mux_ctl.sv
`timescale 1ns/1ps
module test_hs_bd_mux_ctl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in0_req = 1'b0, in1_req = 1'b0, ctl_req = 1'b0, ctl_sel = 1'b0, out_ack = 1'b0;
    logic [W-1:0] in0_data = '0, in1_data = '0;
    logic         in0_ack, in1_ack, ctl_ack, out_req;
    logic [W-1:0] out_data;

    int total = 0;
    int bad = 0;
    bit busy = 0;
    bit stray = 0;
    bit sel_now = 0;

    always #2.5 clk = ~clk;

    hs_bd_mux_ctl #(.DATA_W(W)) i_hs_bd_mux_ctl (
        .clk(clk), .rst_n(rst_n),
        .in0_req(in0_req), .in0_ack(in0_ack), .in0_data(in0_data),
        .in1_req(in1_req), .in1_ack(in1_ack), .in1_data(in1_data),
        .ctl_req(ctl_req), .ctl_sel(ctl_sel), .ctl_ack(ctl_ack),
        .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
    );

    // R1: watch the unselected acknowledge during every transfer
    always @(negedge clk) begin
        if (busy && (sel_now ? in0_ack : in1_ack)) stray = 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic rd(input int which);
        case (which)
            0: rd = out_req;
            1: rd = ctl_ack;
            2: rd = in0_ack;
            default: rd = in1_ack;
        endcase
    endfunction

    task automatic wait_for(input int which, input logic val, output bit ok);
        ok = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rd(which) == val) begin
                ok = 1;
                return;
            end
        end
    endtask

    task automatic set_req(input bit sel, input logic v);
        if (sel) in1_req = v; else in0_req = v;
    endtask

    // One full four-phase transfer; pend raises the other input too,
    // lead raises the data request some cycles before the select request.
    task automatic xfer(input bit sel, input bit pend, input bit lead);
        bit ok;
        logic [W-1:0] d0, d1, exp;
        d0 = W'($urandom);
        d1 = W'($urandom);
        exp = sel ? d1 : d0;
        @(negedge clk);
        stray = 0; sel_now = sel; busy = 1;
        in0_data = d0; in1_data = d1;
        if (lead) begin
            set_req(sel, 1'b1);
            if (pend) set_req(!sel, 1'b1);
            repeat (3) @(negedge clk);
            chk(out_req == 1'b0, "R3 no out_req without ctl_req", out_req, 0);
        end
        ctl_sel = sel; ctl_req = 1'b1;
        set_req(sel, 1'b1);
        if (pend) set_req(!sel, 1'b1);
        wait_for(0, 1'b1, ok);
        chk(ok, "R3 out_req rise", out_req, 1);
        chk(out_data == exp, "R6 data at out_req", out_data, exp);
        out_ack = 1'b1;
        wait_for(sel ? 3 : 2, 1'b1, ok);
        chk(ok, "R2 selected ack rise", sel ? in1_ack : in0_ack, 1);
        chk(ctl_ack == 1'b1, "R5 ctl_ack with ack", ctl_ack, 1);
        if (sel) in0_data = ~d0; else in1_data = ~d1;
        @(negedge clk);
        chk(out_data == exp, "R6 data held", out_data, exp);
        ctl_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_req == 1'b1, "R4 out_req held by data req", out_req, 1);
        set_req(sel, 1'b0);
        wait_for(0, 1'b0, ok);
        chk(ok, "R4 out_req fall", out_req, 0);
        chk(out_data == exp, "R6 data until out_ack fall", out_data, exp);
        out_ack = 1'b0;
        wait_for(sel ? 3 : 2, 1'b0, ok);
        chk(ok, "R2 selected ack fall", sel ? in1_ack : in0_ack, 0);
        wait_for(1, 1'b0, ok);
        chk(ok, "R5 ctl_ack fall", ctl_ack, 0);
        @(negedge clk);
        set_req(!sel, 1'b0);
        busy = 0;
        chk(!stray, "R1 unselected never acked", stray, 0);
    endtask

    task automatic t_reset();
        in0_data = 8'h5A; in1_data = 8'hA5;
        repeat (3) @(negedge clk);
        chk(out_req == 0 && ctl_ack == 0, "R7 reset out_req/ctl_ack", {out_req, ctl_ack}, 0);
        chk(in0_ack == 0 && in1_ack == 0, "R7 reset acks", {in0_ack, in1_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_data == 8'h5A, "R7 selection points to in0", out_data, 8'h5A);
        chk(out_req == 0 && ctl_ack == 0, "R7 after reset", {out_req, ctl_ack}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        xfer(1'b0, 1'b0, 1'b0);
        xfer(1'b1, 1'b0, 1'b0);
        xfer(1'b1, 1'b1, 1'b1);
        xfer(1'b0, 1'b1, 1'b1);
        xfer(1'b1, 1'b0, 1'b1);
        for (int n = 0; n < 24; n++) begin
            xfer(1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule